// File: doc/BRIEF.md
# Two-Channel Event Capture Timer

The block timestamps edges on two input pins against one shared 16-bit time base. The time base advances once every (divider + 1) clocks and wraps from 0xFFFF to 0x0000. Each channel runs a short capture sequence on its pin:

- a rising edge is event A;
- a falling edge is event B;
- the time base is latched at the first A, at B, and optionally at a second A.

A configuration register chooses two things per channel. The first is whether the sequence ends at B or at the second A. The second is whether the channel stops after one sequence (single-shot) or starts again at once (free-running). Software arms channels through a control register. A completed sequence sets that channel's bit in a status register, and a read of that register clears it. Each completion also pulses one interrupt line shared by both channels.

Each channel is a four-state machine:

- **S_IDLE**: the channel is disarmed and ignores its pin.
  - `arm` moves it to S_WAIT_A1.
- **S_WAIT_A1**: it waits for the first rising edge.
  - A rising edge latches the first-A time and moves to S_WAIT_B.
- **S_WAIT_B**: it waits for a falling edge.
  - A falling edge latches the B time.
  - If the channel ends on B, the sequence completes. The channel then returns to S_WAIT_A1 (free-running) or S_IDLE (single-shot).
  - Otherwise it moves to S_WAIT_A2.
- **S_WAIT_A2**: it waits for a second rising edge.
  - A rising edge latches the second-A time and completes the sequence, with the same return as above.

From every waiting state, a cleared arm bit forces a return to S_IDLE.

Register map: each address below is a 4-bit value, so 0x3 means address 3.

| Address | Register | Access |
|---|---|---|
| 0x0 | configuration | read/write, 8 bits |
| 0x1 | arm | read/write, 2 bits |
| 0x2 | status | read clears |
| 0x3 | divider | read/write |
| 0x4 | time base | read only |
| 0x5, 0x6, 0x7 | channel 0 first-A, B, second-A captures | read only |
| 0x8, 0x9, 0xA | channel 1 first-A, B, second-A captures | read only |

Read data is combinational from the address. A write takes effect at the clock edge at which `reg_wr` is high.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset, every register listed in the map reads 0. The irq output is 0, and both channels are in S_IDLE.
- R2: Each event pin passes through a two-flop synchronizer. A level change applied before clock edge k is acted on at edge k+2. A capture at that edge stores the time-base value held just before that edge.
- R3: Arm bit 0 (address 0x1) arms channel 0 and arm bit 1 arms channel 1; writing 0 disarms. A channel whose configuration mode bit is clear (single-shot) clears its own arm bit when its sequence completes. It then captures nothing and raises nothing until its arm bit is written to 1 again. A channel that has never been armed ignores its pin.
- R4: Configuration bit 3 (channel 0) and bit 7 (channel 1) set free-running mode. In that mode the arm bit stays 1 after completion, and a new sequence starts from S_WAIT_A1.
- R5: A completion sets status bit 0 (channel 0) or status bit 1 (channel 1). It also drives irq high for exactly one clock cycle, at the same edge as the status bit. Completions of both channels in the same cycle set both bits and give one pulse.
- R6: A read of address 0x2 (status) returns the current bits and clears all of them at that clock edge. A completion in that same cycle still leaves its bit set.
- R7: Configuration bit 2 (channel 0) and bit 6 (channel 1) choose the end event. Set ends the sequence at event B, and clear ends it at the second event A, so an end-on-A channel gives no status or irq at B.
- R8: The time base steps by exactly 1 every (divider + 1) clocks. Writing the divider restarts the prescaler, so 4·(d+1) clocks after writing divider d the time base has advanced by exactly 4. The time base wraps from 0xFFFF to 0x0000.
- R9: A channel's first-A, B and second-A times land in its three capture addresses in that order (0x5 to 0x7 for channel 0, 0x8 to 0xA for channel 1). Each capture holds its value until the same step of a later sequence overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 2 | Asynchronous event pins, bit n for channel n |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status when address is 0x2) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A channel machine stuck in, or skipping, a state shows up at the ports within three clocks of the edge that should have moved it. The symptom is one of three: a missing or extra irq pulse against the expected cycle, a wrong status bit, or a capture register that was not written with the predicted time-base value. A wrong arm bit shows as a single-shot channel that keeps capturing, or a free-running one that stops. Both cases are seen on the next stimulated sequence. Divider and wrap faults appear directly in time-base reads taken a known number of clocks apart.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int TB_W   = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG  = 4'h0;
    localparam logic [ADDR_W-1:0] A_ARM  = 4'h1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h2;
    localparam logic [ADDR_W-1:0] A_DIV  = 4'h3;
    localparam logic [ADDR_W-1:0] A_TB   = 4'h4;
    localparam int                A_CAP  = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_A1,
        S_WAIT_B,
        S_WAIT_A2
    } chan_state_e;
endpackage

// File: rtl/dct_timebase.sv
module dct_timebase #(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] div_i,
    input  logic            div_load_i,
    output logic [TB_W-1:0] tb_o
);
    logic [TB_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre  <= '0;
            tb_o <= '0;
        end else if (div_load_i) begin
            pre <= '0;
        end else if (pre == div_i) begin
            pre  <= '0;
            tb_o <= tb_o + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_o != $past(tb_o)) |-> (tb_o == $past(tb_o) + 1'b1)); // R8
endmodule

// File: rtl/dct_edge_sync.sv
module dct_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;
    assign fall_o = ~s2 & s3;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o)); // R2
endmodule

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int TB_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm_i,
    input  logic                 end_on_b_i,
    input  logic                 free_run_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic [TB_W-1:0]      tb_i,
    output logic                 done_o,
    output logic [2:0][TB_W-1:0] caps_o
);
    chan_state_e st, st_nx;
    logic        en_a1, en_b, en_a2;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (arm_i) st_nx = S_WAIT_A1;
            S_WAIT_A1: if (!arm_i) st_nx = S_IDLE;
                       else if (rise_i) st_nx = S_WAIT_B;
            S_WAIT_B:  if (!arm_i) st_nx = S_IDLE;
                       else if (fall_i) begin
                           if (!end_on_b_i)     st_nx = S_WAIT_A2;
                           else if (free_run_i) st_nx = S_WAIT_A1;
                           else                 st_nx = S_IDLE;
                       end
            S_WAIT_A2: if (!arm_i) st_nx = S_IDLE;
                       else if (rise_i) st_nx = free_run_i ? S_WAIT_A1 : S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        en_a1  = 1'b0;
        en_b   = 1'b0;
        en_a2  = 1'b0;
        done_o = 1'b0;
        unique case (st)
            S_IDLE:    ;
            S_WAIT_A1: en_a1 = arm_i & rise_i;
            S_WAIT_B:  begin
                           en_b   = arm_i & fall_i;
                           done_o = arm_i & fall_i & end_on_b_i;
                       end
            S_WAIT_A2: begin
                           en_a2  = arm_i & rise_i;
                           done_o = arm_i & rise_i;
                       end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            caps_o <= '0;
        end else begin
            if (en_a1) caps_o[0] <= tb_i;
            if (en_b)  caps_o[1] <= tb_i;
            if (en_a2) caps_o[2] <= tb_i;
        end
    end

    AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (st == S_IDLE)); // R3
    AST_DONE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (arm_i && st != S_IDLE && st != S_WAIT_A1)); // R7
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
    import dct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        evt_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [TB_W-1:0]   reg_wdata,
    output logic [TB_W-1:0]   reg_rdata,
    output logic              irq
);
    localparam int N_CH  = 2;
    localparam int CFG_W = 4 * N_CH;

    logic [CFG_W-1:0]                 cfg;
    logic [N_CH-1:0]                  arm, done, end_b, free;
    logic [N_CH-1:0]                  stat, rise, fall;
    logic [TB_W-1:0]                  div, tb;
    logic [N_CH-1:0][2:0][TB_W-1:0]   caps;
    logic                             wr_cfg, wr_arm, wr_div, stat_rd;

    assign wr_cfg  = reg_wr && reg_addr == A_CFG;
    assign wr_arm  = reg_wr && reg_addr == A_ARM;
    assign wr_div  = reg_wr && reg_addr == A_DIV;
    assign stat_rd = reg_rd && reg_addr == A_STAT;

    dct_timebase #(.TB_W(TB_W)) i_tb (
        .clk(clk), .rst_n(rst_n), .div_i(div), .div_load_i(wr_div), .tb_o(tb)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign end_b[c] = cfg[4*c+2];
        assign free[c]  = cfg[4*c+3];

        dct_edge_sync i_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(evt_in[c]),
            .rise_o(rise[c]), .fall_o(fall[c])
        );

        dct_channel #(.TB_W(TB_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .arm_i(arm[c]),
            .end_on_b_i(end_b[c]), .free_run_i(free[c]),
            .rise_i(rise[c]), .fall_i(fall[c]), .tb_i(tb),
            .done_o(done[c]), .caps_o(caps[c])
        );

        AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
            (done[c] && !free[c] && !wr_arm) |=> !arm[c]); // R3
        AST_FREE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (done[c] && free[c] && !wr_arm) |=> arm[c]); // R4
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= '0;
            arm  <= '0;
            div  <= '0;
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            if (wr_cfg) cfg <= reg_wdata[CFG_W-1:0];
            if (wr_div) div <= reg_wdata;
            if (wr_arm) arm <= reg_wdata[N_CH-1:0];
            else        arm <= arm & ~(done & ~free);
            stat <= (stat & ~{N_CH{stat_rd}}) | done;
            irq  <= |done;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:   reg_rdata = TB_W'(cfg);
            A_ARM:   reg_rdata = TB_W'(arm);
            A_STAT:  reg_rdata = TB_W'(stat);
            A_DIV:   reg_rdata = div;
            A_TB:    reg_rdata = tb;
            default: begin
                for (int c = 0; c < N_CH; c++)
                    for (int k = 0; k < 3; k++)
                        if (reg_addr == ADDR_W'(A_CAP + 3*c + k))
                            reg_rdata = caps[c][k];
            end
        endcase
    end

    AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0)); // R5
    AST_STATUS_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && done == '0) |=> (stat == '0)); // R6
endmodule

// File: tb/test_dual_capture_timer.sv
module test_dual_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  evt_in = 2'b00;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_q[$];
    logic [15:0] d, t0, t1, t2, t3;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_capture_timer i_dual_capture_timer (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: applies a level, predicts capture time, pushes expected irq cycle
    task automatic ev(input logic [1:0] mask, input logic lvl, input bit exp_irq,
                      output logic [15:0] tcap);
        @(negedge clk);
        for (int c = 0; c < 2; c++) if (mask[c]) evt_in[c] = lvl;
        reg_addr = 4'h4;
        #1 tcap = reg_rdata + 16'd2;
        if (exp_irq) exp_q.push_back(cyc + 3);
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops expected irq cycles
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected irq", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R5 irq cycle", cyc, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        for (int a = 0; a < 11; a++) begin
            if (a == 4) continue;
            rd(4'(a), d);
            check(d == 16'h0, "R1 register", d, 0);
        end

        // R3 never-armed channel ignores its pin
        ev(2'b01, 1'b1, 0, t0);
        ev(2'b01, 1'b0, 0, t0);
        rd(4'h5, d); check(d == 16'h0, "R3 disarmed capture", d, 0);
        rd(4'h2, d); check(d == 16'h0, "R3 disarmed status", d, 0);

        // ch0: end on B (bit2), single-shot
        wr(4'h0, 16'h0004);
        wr(4'h1, 16'h0001);
        repeat (2) @(negedge clk);
        ev(2'b01, 1'b1, 0, t0);
        ev(2'b01, 1'b0, 1, t1);
        rd(4'h5, d); check(d == t0, "R2 R9 ch0 first A", d, t0);
        rd(4'h6, d); check(d == t1, "R2 R9 ch0 B", d, t1);
        rd(4'h2, d); check(d == 16'h1, "R5 ch0 status", d, 1);
        rd(4'h2, d); check(d == 16'h0, "R6 read clears", d, 0);
        rd(4'h1, d); check(d == 16'h0, "R3 single-shot disarms", d, 0);
        ev(2'b01, 1'b1, 0, t2);
        ev(2'b01, 1'b0, 0, t2);
        rd(4'h5, d); check(d == t0, "R3 no capture after single-shot", d, t0);
        rd(4'h2, d); check(d == 16'h0, "R3 no status after single-shot", d, 0);
        // re-arm
        wr(4'h1, 16'h0001);
        repeat (2) @(negedge clk);
        ev(2'b01, 1'b1, 0, t0);
        ev(2'b01, 1'b0, 1, t1);
        rd(4'h6, d); check(d == t1, "R3 re-armed capture", d, t1);
        rd(4'h2, d); check(d == 16'h1, "R3 re-armed status", d, 1);

        // ch1: end on second A (bit6 clear), free-running (bit7)
        wr(4'h0, 16'h0080);
        wr(4'h1, 16'h0002);
        repeat (2) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            ev(2'b10, 1'b1, 0, t0);
            ev(2'b10, 1'b0, 0, t1);
            rd(4'h2, d); check(d == 16'h0, "R7 no end at B", d, 0);
            ev(2'b10, 1'b1, 1, t2);
            rd(4'h8, d); check(d == t0, "R9 ch1 first A", d, t0);
            rd(4'h9, d); check(d == t1, "R9 ch1 B", d, t1);
            rd(4'hA, d); check(d == t2, "R9 ch1 second A", d, t2);
            rd(4'h2, d); check(d == 16'h2, "R5 ch1 status", d, 2);
            rd(4'h1, d); check(d == 16'h2, "R4 free-run keeps arm", d, 2);
            ev(2'b10, 1'b0, 0, t3);
        end

        // both channels end on B, free-running, complete together
        wr(4'h0, 16'h00CC);
        wr(4'h1, 16'h0003);
        repeat (2) @(negedge clk);
        ev(2'b11, 1'b1, 0, t0);
        ev(2'b11, 1'b0, 1, t1);
        rd(4'h2, d); check(d == 16'h3, "R5 both status bits", d, 3);
        rd(4'h6, d); check(d == t1, "R9 ch0 B joint", d, t1);
        rd(4'h9, d); check(d == t1, "R9 ch1 B joint", d, t1);
        wr(4'h1, 16'h0000);

        // R8 divider
        wr(4'h3, 16'h0003);
        #1 t0 = reg_rdata;
        reg_addr = 4'h4; #1 t0 = reg_rdata;
        repeat (16) @(negedge clk);
        #1 d = reg_rdata;
        check(d == t0 + 16'd4, "R8 divider rate", d, t0 + 16'd4);
        wr(4'h3, 16'h0000);

        // R8 wrap
        reg_addr = 4'h4; #1 t0 = reg_rdata;
        repeat (int'(16'hFFFF - t0)) @(negedge clk);
        #1 d = reg_rdata;
        check(d == 16'hFFFF, "R8 reaches max", d, 16'hFFFF);
        @(negedge clk); #1 d = reg_rdata;
        check(d == 16'h0000, "R8 wraps", d, 0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5 missing irq", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule